// File: doc/BRIEF.md
# Shape-Configurable Synchronous RAM with Activation Counters

This block is a synchronous memory with one write side and one read side. A static parameter picks its word width, and the word count follows from that width. The parameter selects one of five shapes, from a deep single-bit array to a shallow 18-bit array. Each side has two controls: an operation enable that decides whether data moves, and a clock enable that decides whether the side's internal circuitry fires at all on that edge.

Every edge on which a side's clock enable is high counts as an internal activation. This stands in for the bit-line precharge that consumes most dynamic power, and it happens whether or not data actually moves. A saturating counter per side tallies these activations. A testbench or a mapping study can therefore compare how many activations were wasted when an operation enable, rather than the clock enable, was used to gate the accesses.

Top module: `cfg_aspect_ram`

## Requirements
- R1: The parameter DATA_W selects the shape: 1→4096 words, 2→2048, 4→1024, 9→512, 18→256. The address uses log2(words) bits, taken from the low end of the 12-bit address ports.
- R2: A word is written on a rising edge only when wrEn and wrClkEn are both high at that edge. With either one low, the stored contents do not change.
- R3: A read happens on a rising edge only when rdEn and rdClkEn are both high. The addressed word appears on rdData one cycle after the edge that samples the address.
- R4: On an edge without a read (rdEn or rdClkEn low), rdData keeps its previous value.
- R5: Address bits at or above log2(words) are ignored on both ports. With DATA_W=9, address 0x005 and address 0x205 name the same word.
- R6: When a read and a write hit the same address on the same edge, rdData returns the contents from before the write. The new data is visible to the next read.
- R7: wrActCount rises by one on every edge where wrClkEn is high, and rdActCount rises by one on every edge where rdClkEn is high, regardless of wrEn or rdEn. A side whose clock enable is low does not count.
- R8: actClear is a synchronous clear that sets both counters to zero on the next edge. It takes priority over counting.
- R9: Each counter is CNT_W bits wide and saturates at its all-ones value.
- R10: While rstN is low (asynchronous, active low), rdData and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wrAddr | input | 12 | Write address (low bits used) |
| wrData | input | DATA_W | Write data |
| wrEn | input | 1 | Write operation enable |
| wrClkEn | input | 1 | Write side clock enable |
| rdAddr | input | 12 | Read address (low bits used) |
| rdEn | input | 1 | Read operation enable |
| rdClkEn | input | 1 | Read side clock enable |
| rdData | output | DATA_W | Registered read data |
| actClear | input | 1 | Synchronous clear of both counters |
| wrActCount | output | CNT_W | Write side activation count |
| rdActCount | output | CNT_W | Read side activation count |

## Verification
The embedded properties watch the counters and the read register on every cycle. They check that a counter steps by exactly one on an activating edge, stays put otherwise, sticks at its ceiling and returns to zero on a clear. They also check that rdData holds on any edge without a read. Whether a blocked write really left the array untouched, whether high address bits alias, and whether a collision returns the old word can only be seen through the bench's scenarios, which read back stored data through the normal port.

// File: rtl/cfg_aspect_ram_pkg.sv
package cfg_aspect_ram_pkg;

  localparam int ADDR_PORT_W = 12;

  typedef struct packed {
    logic wrDo;   // data moves into the array
    logic rdDo;   // data moves to the output register
    logic wrAct;  // write side fires internally
    logic rdAct;  // read side fires internally
  } ramStrobes_t;

  function automatic int wordsForWidth(input int w);
    case (w)
      1:       return 4096;
      2:       return 2048;
      4:       return 1024;
      9:       return 512;
      18:      return 256;
      default: return 512;
    endcase
  endfunction

endpackage

// File: rtl/cfg_aspect_ram_ctrl.sv
module cfg_aspect_ram_ctrl
  import cfg_aspect_ram_pkg::*;
(
  input  logic        wrEn,
  input  logic        wrClkEn,
  input  logic        rdEn,
  input  logic        rdClkEn,
  output ramStrobes_t strb
);

  always_comb begin
    strb.wrAct = wrClkEn;
    strb.rdAct = rdClkEn;
    strb.wrDo  = wrClkEn & wrEn;
    strb.rdDo  = rdClkEn & rdEn;
  end

endmodule

// File: rtl/cfg_aspect_ram_dp.sv
module cfg_aspect_ram_dp
  import cfg_aspect_ram_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int WORDS  = 512,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ramStrobes_t            strb,
  input  logic [ADDR_PORT_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [ADDR_PORT_W-1:0] rdAddr,
  output logic [DATA_W-1:0]      rdData
);

  logic [DATA_W-1:0] cells [WORDS];
  logic [AW-1:0]     wrIdx;
  logic [AW-1:0]     rdIdx;

  assign wrIdx = wrAddr[AW-1:0];
  assign rdIdx = rdAddr[AW-1:0];

  always_ff @(posedge clk) begin
    if (strb.wrDo) cells[wrIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdDo) rdData <= cells[rdIdx];
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdDo |=> $stable(rdData)); // R4

endmodule

// File: rtl/cfg_aspect_ram_actcnt.sv
module cfg_aspect_ram_actcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CEIL = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     count <= '0;
    else if (clr)                  count <= '0;
    else if (inc && count != CEIL) count <= count + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && inc && count != CEIL) |=> count == $past(count) + 1'b1); // R7
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !inc) |=> $stable(count)); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> count == '0); // R8
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && count == CEIL) |=> count == CEIL); // R9

endmodule

// File: rtl/cfg_aspect_ram.sv
module cfg_aspect_ram
  import cfg_aspect_ram_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int CNT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_PORT_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   wrEn,
  input  logic                   wrClkEn,
  input  logic [ADDR_PORT_W-1:0] rdAddr,
  input  logic                   rdEn,
  input  logic                   rdClkEn,
  output logic [DATA_W-1:0]      rdData,
  input  logic                   actClear,
  output logic [CNT_W-1:0]       wrActCount,
  output logic [CNT_W-1:0]       rdActCount
);

  localparam int WORDS = wordsForWidth(DATA_W);

  ramStrobes_t strb;

  cfg_aspect_ram_ctrl i_ctrl (
    .wrEn(wrEn), .wrClkEn(wrClkEn), .rdEn(rdEn), .rdClkEn(rdClkEn), .strb(strb)
  );

  cfg_aspect_ram_dp #(.DATA_W(DATA_W), .WORDS(WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic             sideInc;
    logic [CNT_W-1:0] sideCount;
    assign sideInc = (s == 0) ? strb.wrAct : strb.rdAct;
    cfg_aspect_ram_actcnt #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rstN(rstN), .inc(sideInc), .clr(actClear), .count(sideCount)
    );
  end

  assign wrActCount = g_side[0].sideCount;
  assign rdActCount = g_side[1].sideCount;

endmodule

// File: tb/test_cfg_aspect_ram.sv
module test_cfg_aspect_ram;

  localparam int DW = 9;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          wrEn = 1'b0, wrClkEn = 1'b0;
  logic [11:0]   rdAddr = '0;
  logic          rdEn = 1'b0, rdClkEn = 1'b0;
  logic [DW-1:0] rdData;
  logic          actClear = 1'b0;
  logic [CW-1:0] wrActCount, rdActCount;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cfg_aspect_ram #(.DATA_W(DW), .CNT_W(CW)) i_cfg_aspect_ram (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData), .wrEn(wrEn),
    .wrClkEn(wrClkEn), .rdAddr(rdAddr), .rdEn(rdEn), .rdClkEn(rdClkEn),
    .rdData(rdData), .actClear(actClear), .wrActCount(wrActCount),
    .rdActCount(rdActCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    wrEn = 0; wrClkEn = 0; rdEn = 0; rdClkEn = 0; actClear = 0;
  endtask

  task automatic doWrite(input int a, input int d);
    wrAddr = 12'(a); wrData = DW'(d); wrEn = 1; wrClkEn = 1;
    tick();
    idle();
  endtask

  task automatic doRead(input int a, output int d);
    rdAddr = 12'(a); rdEn = 1; rdClkEn = 1;
    tick();
    d = int'(rdData);
    idle();
  endtask

  task automatic testReset();
    check("R10 rdData in reset", int'(rdData), 0);
    check("R10 wrActCount in reset", int'(wrActCount), 0);
    check("R10 rdActCount in reset", int'(rdActCount), 0);
  endtask

  task automatic testBasic();
    int d;
    doWrite(0, 'h1A5); doWrite(511, 'h0FF); doWrite(5, 'h123); doWrite(100, 'h000);
    doRead(0, d);   check("R1/R2/R3 addr 0", d, 'h1A5);
    doRead(511, d); check("R1 top word 511", d, 'h0FF);
    doRead(5, d);   check("R3 addr 5", d, 'h123);
    doRead(100, d); check("R3 addr 100", d, 'h000);
  endtask

  task automatic testBlockedWrite();
    int d;
    wrAddr = 12'd5; wrData = 9'h0AA; wrEn = 0; wrClkEn = 1; tick(); idle();
    doRead(5, d); check("R2 wrEn low no write", d, 'h123);
    wrAddr = 12'd5; wrData = 9'h0BB; wrEn = 1; wrClkEn = 0; tick(); idle();
    doRead(5, d); check("R2 wrClkEn low no write", d, 'h123);
  endtask

  task automatic testReadHold();
    int d;
    doRead(0, d);
    rdAddr = 12'd511; rdEn = 0; rdClkEn = 1; tick();
    check("R4 hold with rdEn low", int'(rdData), 'h1A5);
    rdEn = 1; rdClkEn = 0; tick();
    check("R4 hold with rdClkEn low", int'(rdData), 'h1A5);
    idle();
  endtask

  task automatic testAlias();
    int d;
    doWrite('h205, 'h155);
    doRead(5, d); check("R5 high write bits ignored", d, 'h155);
    doWrite(7, 'h0C3);
    doRead('hE07, d); check("R5 high read bits ignored", d, 'h0C3);
  endtask

  task automatic testCollision();
    int d;
    doWrite(30, 'h011);
    wrAddr = 12'd30; wrData = 9'h122; wrEn = 1; wrClkEn = 1;
    rdAddr = 12'd30; rdEn = 1; rdClkEn = 1;
    tick(); idle();
    check("R6 same-edge read returns old", int'(rdData), 'h011);
    doRead(30, d); check("R6 next read sees new", d, 'h122);
  endtask

  task automatic testCounters();
    actClear = 1; wrClkEn = 1; rdClkEn = 1; tick(); idle();
    check("R8 clear beats increment wr", int'(wrActCount), 0);
    check("R8 clear beats increment rd", int'(rdActCount), 0);
    for (int i = 0; i < 5; i++) begin
      wrClkEn = 1; wrEn = 0; rdClkEn = (i < 3); rdEn = 0; tick();
    end
    idle();
    for (int i = 0; i < 4; i++) begin
      wrEn = 1; rdEn = 1; tick();
    end
    idle();
    check("R7 wr activations despite wrEn low", int'(wrActCount), 5);
    check("R7 rd activations despite rdEn low", int'(rdActCount), 3);
    wrClkEn = 1;
    for (int i = 0; i < 70; i++) tick();
    idle();
    check("R9 wr counter saturates", int'(wrActCount), (1 << CW) - 1);
    check("R7 rd counter unchanged", int'(rdActCount), 3);
    actClear = 1; tick(); idle();
    check("R8 clear wr", int'(wrActCount), 0);
    check("R8 clear rd", int'(rdActCount), 0);
  endtask

  initial begin
    #20;
    testReset();
    @(negedge clk); rstN = 1;
    tick();
    testBasic();
    testBlockedWrite();
    testReadHold();
    testAlias();
    testCollision();
    testCounters();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule